// File: doc/BRIEF.md
# Transmit Byte Holding Register with Idle Fill and Self-Test Pattern

This block sits in front of an 8B/10B encoder in a serial-link transmitter. Once per byte clock it presents one character to the encoder: eight data bits, a flag that selects special-character coding, and a flag that asks for a deliberate code violation. The character comes from the user's inputs when a load is requested. Otherwise the block fills the slot with the K28.5 idle comma, which keeps the far end's receiver aligned.

Two active-low load requests are provided. The immediate request loads the inputs present at the same rising edge. The deferred request loads the inputs present at the following rising edge, whatever the requests are at that edge. This lets the block take bytes from FIFOs that present data with or without a cycle of latency. A flag on the output tells later logic whether the byte came from the user or is idle fill.

In self-test mode the register becomes a 9-bit LFSR. It emits a repeating 511-character pattern that contains data characters, special characters and one violation request per period. The pattern starts with the all-zero data character, so a matching receiver can align to it.

Top module: `txin_reg`

## Requirements
- R1: A synchronous active-high reset makes the output the idle comma (special flag 1, data 0xBC, violation 0, user flag 0) and drops any pending deferred load.
- R2: Outside self-test, when `ld_now_n` is 0 at a rising edge, the data, special flag and violation inputs present at that edge appear on the outputs after that edge, with the user flag set to 1.
- R3: Outside self-test, when `ld_defer_n` is 0 at a rising edge, the inputs present at the following rising edge are loaded at that edge, whatever values `ld_now_n` and `ld_defer_n` have at that second edge.
- R4: Outside self-test, at a rising edge with `ld_now_n` at 1 and no deferred load pending, the output becomes the idle comma with the user flag at 0.
- R5: A loaded byte passes the violation input through unchanged, and a filled byte never carries a violation request.
- R6: On the first rising edge with `self_test` at 1, the output becomes the all-zero data character: data 0x00, special flag 0, violation 0, user flag 1.
- R7: In self-test the generator state s (9 bits, seed 0x1FF at entry) advances each edge as s' = {s[7:0], s[8] xor s[4]}. The output is data = ~s[7:0] and special flag = ~s[8]. The sequence repeats every 511 edges, and the all-zero data character appears exactly once per period.
- R8: In self-test the violation flag is 1 only for generator state 0x001 (data 0xFE, special flag 1), which occurs exactly once per 511-character period.
- R9: A deferred load requested on an edge where `self_test` is 1 is discarded. The first edge after self-test ends, with no requests active, gives the idle comma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_now_n | input | 1 | Active-low request to load the inputs at this edge |
| ld_defer_n | input | 1 | Active-low request to load the inputs at the next edge |
| self_test | input | 1 | Selects the LFSR pattern generator |
| in_data | input | 8 | User data byte |
| in_kchar | input | 1 | User special-character select |
| in_viol | input | 1 | User request to send a code violation |
| q_data | output | 8 | Data byte to the encoder |
| q_kchar | output | 1 | Special-character select to the encoder |
| q_viol | output | 1 | Violation request to the encoder |
| q_user | output | 1 | 1 when the byte is user data or self-test pattern, 0 for idle fill |

## Verification
The bench sweeps all 512 data and special-flag values through the immediate path and through the deferred path. In the deferred sweep the second edge carries released or conflicting requests, and the inputs change between the two edges. A design that latched deferred data at the requesting edge, or that obeyed the requests present at the second edge, shows the wrong byte here. Reset is applied while a deferred request is pending. The same is done at self-test exit, so a pending load that leaks through would show user data where the comma is expected. The full 511-step pattern is followed against an arithmetic model. This checks the first character, the single violation, and that the all-zero character returns only after exactly 511 steps, which catches a wrong tap, a wrong seed or an early wrap.

// File: rtl/txin_pkg.sv
package txin_pkg;

  localparam int unsigned TXIN_DATA_W = 8;
  localparam int unsigned TXIN_TAP    = 5;

  typedef enum logic [1:0] {
    SRC_FILL = 2'd0,
    SRC_USER = 2'd1,
    SRC_PAT  = 2'd2
  } txin_src_e;

endpackage

// File: rtl/txin_load_ctl.sv
module txin_load_ctl (
  input  logic clk,
  input  logic rst,
  input  logic self_test,
  input  logic ld_now_n,
  input  logic ld_defer_n,
  output logic load_ev,
  output logic pend_q
);

  // A deferred request arms a one-shot load for the next edge.
  // Self-test and reset both discard it.
  always_ff @(posedge clk) begin
    if (rst || self_test) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= ~ld_defer_n;
    end
  end

  assign load_ev = ~self_test & (~ld_now_n | pend_q);

endmodule

// File: rtl/txin_bist_gen.sv
module txin_bist_gen #(
  parameter int unsigned STATE_W = 9,
  parameter int unsigned TAP     = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               self_test,
  output logic [STATE_W-1:0] pat_nxt,
  output logic               pat_run_q
);

  localparam logic [STATE_W-1:0] SEED = '1;

  logic [STATE_W-1:0] pat_q;

  function automatic logic [STATE_W-1:0] lfsr_adv(input logic [STATE_W-1:0] s);
    return {s[STATE_W-2:0], s[STATE_W-1] ^ s[TAP-1]};
  endfunction

  assign pat_nxt = pat_run_q ? lfsr_adv(pat_q) : SEED;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q     <= SEED;
      pat_run_q <= 1'b0;
    end else begin
      pat_run_q <= self_test;
      if (self_test) begin
        pat_q <= pat_nxt;
      end
    end
  end

endmodule

// File: rtl/txin_out_sel.sv
module txin_out_sel
  import txin_pkg::*;
#(
  parameter int unsigned          DATA_W     = 8,
  parameter logic [DATA_W-1:0]    COMMA      = 8'hBC,
  parameter logic [DATA_W:0]      VIOL_STATE = 1
) (
  input  txin_src_e           src,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                in_kchar,
  input  logic                in_viol,
  input  logic [DATA_W:0]     pat_state,
  output logic [DATA_W-1:0]   d_data,
  output logic                d_kchar,
  output logic                d_viol,
  output logic                d_user
);

  function automatic logic [DATA_W-1:0] pat_data(input logic [DATA_W:0] s);
    return ~s[DATA_W-1:0];
  endfunction

  function automatic logic pat_kchar(input logic [DATA_W:0] s);
    return ~s[DATA_W];
  endfunction

  always_comb begin
    unique case (src)
      SRC_USER: begin
        d_data  = in_data;
        d_kchar = in_kchar;
        d_viol  = in_viol;
        d_user  = 1'b1;
      end
      SRC_PAT: begin
        d_data  = pat_data(pat_state);
        d_kchar = pat_kchar(pat_state);
        d_viol  = (pat_state == VIOL_STATE);
        d_user  = 1'b1;
      end
      default: begin
        d_data  = COMMA;
        d_kchar = 1'b1;
        d_viol  = 1'b0;
        d_user  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/txin_reg.sv
module txin_reg
  import txin_pkg::*;
#(
  parameter int unsigned DATA_W     = TXIN_DATA_W,
  parameter int unsigned TAP        = TXIN_TAP,
  parameter logic [7:0]  COMMA      = 8'hBC,
  parameter int unsigned VIOL_STATE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_now_n,
  input  logic              ld_defer_n,
  input  logic              self_test,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_kchar,
  input  logic              in_viol,
  output logic [DATA_W-1:0] q_data,
  output logic              q_kchar,
  output logic              q_viol,
  output logic              q_user
);

  localparam int unsigned       STATE_W  = DATA_W + 1;
  localparam logic [STATE_W-1:0] VSTATE  = STATE_W'(VIOL_STATE);
  localparam logic [DATA_W-1:0]  COMMA_W = DATA_W'(COMMA);

  // Internal events brought out for the checker.
  logic               load_ev;
  logic               pend_q;
  logic               pat_run_q;
  logic [STATE_W-1:0] pat_nxt;
  txin_src_e          src;

  logic [DATA_W-1:0]  d_data;
  logic               d_kchar;
  logic               d_viol;
  logic               d_user;

  txin_load_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .self_test  (self_test),
    .ld_now_n   (ld_now_n),
    .ld_defer_n (ld_defer_n),
    .load_ev    (load_ev),
    .pend_q     (pend_q)
  );

  txin_bist_gen #(
    .STATE_W (STATE_W),
    .TAP     (TAP)
  ) u_gen (
    .clk       (clk),
    .rst       (rst),
    .self_test (self_test),
    .pat_nxt   (pat_nxt),
    .pat_run_q (pat_run_q)
  );

  always_comb begin
    if (self_test)    src = SRC_PAT;
    else if (load_ev) src = SRC_USER;
    else              src = SRC_FILL;
  end

  txin_out_sel #(
    .DATA_W     (DATA_W),
    .COMMA      (COMMA_W),
    .VIOL_STATE (VSTATE)
  ) u_sel (
    .src       (src),
    .in_data   (in_data),
    .in_kchar  (in_kchar),
    .in_viol   (in_viol),
    .pat_state (pat_nxt),
    .d_data    (d_data),
    .d_kchar   (d_kchar),
    .d_viol    (d_viol),
    .d_user    (d_user)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_data  <= COMMA_W;
      q_kchar <= 1'b1;
      q_viol  <= 1'b0;
      q_user  <= 1'b0;
    end else begin
      q_data  <= d_data;
      q_kchar <= d_kchar;
      q_viol  <= d_viol;
      q_user  <= d_user;
    end
  end

endmodule

// File: rtl/txin_reg_chk.sv
module txin_reg_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_now_n,
  input logic              ld_defer_n,
  input logic              self_test,
  input logic [DATA_W-1:0] in_data,
  input logic              in_kchar,
  input logic              in_viol,
  input logic [DATA_W-1:0] q_data,
  input logic              q_kchar,
  input logic              q_viol,
  input logic              q_user,
  input logic              pend_q,
  input logic              pat_run_q
);

  a_r1_reset_comma: assert property (@(posedge clk)
    rst |=> (q_kchar && q_data == 8'hBC && !q_viol && !q_user));

  a_r2_now_load: assert property (@(posedge clk) disable iff (rst)
    (!self_test && !ld_now_n) |=>
      (q_user && q_data == $past(in_data) && q_kchar == $past(in_kchar)
       && q_viol == $past(in_viol)));

  a_r3_defer_load: assert property (@(posedge clk) disable iff (rst)
    (!self_test && !ld_defer_n) ##1 !self_test |=>
      (q_user && q_data == $past(in_data) && q_kchar == $past(in_kchar)));

  a_r4_idle_fill: assert property (@(posedge clk) disable iff (rst)
    (!self_test && ld_now_n && !pend_q) |=>
      (q_kchar && q_data == 8'hBC && !q_viol && !q_user));

  a_r5_fill_no_viol: assert property (@(posedge clk) disable iff (rst)
    !q_user |-> !q_viol);

  a_r6_bist_entry: assert property (@(posedge clk) disable iff (rst)
    (self_test && !pat_run_q) |=>
      (q_data == '0 && !q_kchar && !q_viol && q_user));

  a_r8_viol_char: assert property (@(posedge clk) disable iff (rst)
    (q_viol && $past(self_test)) |-> (q_kchar && q_data == 8'hFE));

  a_r9_exit_clean: assert property (@(posedge clk) disable iff (rst)
    self_test |=> !pend_q);

endmodule

bind txin_reg txin_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ld_now_n   (ld_now_n),
  .ld_defer_n (ld_defer_n),
  .self_test  (self_test),
  .in_data    (in_data),
  .in_kchar   (in_kchar),
  .in_viol    (in_viol),
  .q_data     (q_data),
  .q_kchar    (q_kchar),
  .q_viol     (q_viol),
  .q_user     (q_user),
  .pend_q     (pend_q),
  .pat_run_q  (pat_run_q)
);

// File: tb/test_txin_reg.sv
module test_txin_reg;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_now_n = 1'b1;
  logic       ld_defer_n = 1'b1;
  logic       self_test = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_kchar = 1'b0;
  logic       in_viol = 1'b0;
  logic [7:0] q_data;
  logic       q_kchar;
  logic       q_viol;
  logic       q_user;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  txin_reg i_txin_reg (
    .clk        (clk),
    .rst        (rst),
    .ld_now_n   (ld_now_n),
    .ld_defer_n (ld_defer_n),
    .self_test  (self_test),
    .in_data    (in_data),
    .in_kchar   (in_kchar),
    .in_viol    (in_viol),
    .q_data     (q_data),
    .q_kchar    (q_kchar),
    .q_viol     (q_viol),
    .q_user     (q_user)
  );

  // Packed view {data, kchar, viol, user}.
  function automatic logic [10:0] pack(input logic [7:0] d, input logic k,
                                       input logic v, input logic u);
    return {d, k, v, u};
  endfunction

  localparam logic [10:0] COMMA_EXP = {8'hBC, 1'b1, 1'b0, 1'b0};
  localparam logic [10:0] D00_EXP   = {8'h00, 1'b0, 1'b0, 1'b1};

  task automatic check(input string req, input logic [10:0] exp);
    logic [10:0] act;
    act = pack(q_data, q_kchar, q_viol, q_user);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Advance one edge and settle away from it.
  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] s;
    int viol_cnt;
    int d00_cnt;

    // R1: reset with a deferred request pending
    ld_defer_n = 1'b0;
    tick; tick;
    check("R1 reset output", COMMA_EXP);
    rst = 1'b0;
    ld_defer_n = 1'b1;
    tick;
    check("R1 pending dropped by reset", COMMA_EXP);

    // R4: idle fill with no requests
    in_data = 8'h5A; in_kchar = 1'b0; in_viol = 1'b1;
    tick;
    check("R4 idle comma", COMMA_EXP);

    // R2 and R5: immediate load sweep over all data and kchar values
    for (int i = 0; i < 512; i++) begin
      ld_now_n = 1'b0;
      in_data  = i[7:0];
      in_kchar = i[8];
      in_viol  = i[0] ^ i[3];
      tick;
      check("R2 immediate load", pack(i[7:0], i[8], i[0] ^ i[3], 1'b1));
    end
    ld_now_n = 1'b1;
    in_viol = 1'b1;
    tick;
    check("R5 fill carries no violation", COMMA_EXP);

    // R3: deferred load sweep; the second edge has varied request values
    for (int i = 0; i < 512; i++) begin
      ld_now_n   = 1'b1;
      ld_defer_n = 1'b0;
      in_data    = ~i[7:0];
      in_kchar   = ~i[8];
      in_viol    = 1'b1;
      tick;
      ld_defer_n = i[1];
      ld_now_n   = i[2];
      in_data    = i[7:0];
      in_kchar   = i[8];
      in_viol    = i[4];
      tick;
      check("R3 deferred load", pack(i[7:0], i[8], i[4], 1'b1));
      ld_defer_n = 1'b1;
      ld_now_n   = 1'b1;
      tick;
      if (i[1] == 1'b0)
        check("R3 chained deferred load", pack(i[7:0], i[8], i[4], 1'b1));
      else
        check("R4 fill after deferred load", COMMA_EXP);
    end

    // R6, R7, R8: self-test pattern over a full period
    ld_defer_n = 1'b0;
    self_test  = 1'b1;
    tick;
    check("R6 first pattern char", D00_EXP);
    s = 9'h1FF;
    viol_cnt = 0;
    d00_cnt  = 0;
    for (int n = 1; n <= 511; n++) begin
      s = {s[7:0], ^(s & 9'h110)};
      tick;
      check("R7 pattern step",
            pack(8'hFF - {1'b0, s[7:0]}, !s[8], s == 9'd1, 1'b1));
      if (q_viol) viol_cnt++;
      if (n < 511 && q_data == 8'h00 && !q_kchar) d00_cnt++;
    end
    total++;
    if (viol_cnt != 1) begin
      bad++;
      $display("FAIL R8: got %0d violations expected 1", viol_cnt);
    end
    total++;
    if (d00_cnt != 0) begin
      bad++;
      $display("FAIL R7: got %0d early D0.0 expected 0", d00_cnt);
    end
    check("R7 period wraps to D0.0", D00_EXP);

    // R9: deferred request raised during self-test is dropped
    self_test  = 1'b0;
    ld_defer_n = 1'b1;
    in_data = 8'h33; in_kchar = 1'b0; in_viol = 1'b0;
    tick;
    check("R9 exit gives comma", COMMA_EXP);
    ld_now_n = 1'b0;
    tick;
    check("R9 normal load after exit", pack(8'h33, 1'b0, 1'b0, 1'b1));

    // R6: re-entry restarts the pattern from the seed
    ld_now_n  = 1'b1;
    self_test = 1'b1;
    tick;
    check("R6 re-entry restarts", D00_EXP);
    self_test = 1'b0;
    tick;
    check("R4 comma after re-entry", COMMA_EXP);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule